// File: doc/BRIEF.md
# Miss-Triggered Stream Prefetch Engine

The block sits beside a last-level cache and looks only at demand misses. Each miss address is reduced to its 64-byte line and compared against a small table of stream entries. A miss close to an entry's last miss, in the same 4 KB page, trains that entry; a miss near no entry takes over the least-recently-used slot as a fresh, unconfirmed stream. Cache hits never reach the block.

When a stream has seen two misses within the trigger distance, it is confirmed and takes its direction from the sign of that step. It then issues line-aligned prefetch requests until its lookahead pointer sits two lines past the latest miss. Each later miss in the stream moves the target forward. Lines already requested are not requested again. A stream never requests a line in a different 4 KB page. A miss in the new page has to train a new stream from scratch. Requests leave through a single valid/ready register that holds its value under backpressure.

Top module: `pfe_stream_prefetch`

## Requirements
- R1: Synchronous active-high reset invalidates every stream and drops any pending request: pfValid is low after reset, and no miss that arrived before reset can lead to a prefetch afterwards.
- R2: A stream's first miss issues nothing. A stream is confirmed only when a later miss lands in the same 4 KB page at a nonzero line distance below TRIGGER_BYTES/64 lines (4 lines, i.e. 256 bytes, by default).
- R3: On confirmation at line L of an ascending stream, requests for lines L+1 and L+2 are issued in that order. pfAddr carries line×64, and its low 6 bits are zero.
- R4: A stream whose confirming step is negative is descending and requests L-1 then L-2.
- R5: Each further qualifying miss at line M extends the lookahead to M+2 (or M-2 when descending). Lines already requested by the stream are not requested again.
- R6: A miss whose line distance from a stream's last miss is 4 lines (256 bytes) or more does not train that stream. It allocates a new unconfirmed entry and issues nothing.
- R7: The stride need not be constant: a +1 line step followed by a +2 line step keeps the stream running.
- R8: No request targets a line outside the 4 KB page of the stream's last miss. A miss in the next page starts an unconfirmed stream and issues nothing until a second close miss arrives in that page.
- R9: While pfReady is low, pfValid stays high and pfAddr stays unchanged. No request is lost.
- R10: A miss that repeats a stream's last line issues nothing and only refreshes that stream's recency.
- R11: The table holds four streams. A miss that matches no stream replaces an invalid entry if one exists, or otherwise the least recently missed-upon one. An evicted stream must retrain before it prefetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| missValid | input | 1 | A demand miss is presented this cycle |
| missAddr | input | 32 | Byte address of the demand miss |
| pfValid | output | 1 | Prefetch request is pending |
| pfAddr | output | 32 | Line-aligned prefetch byte address |
| pfReady | input | 1 | Downstream accepts the request this cycle |

## Verification
The bench goes after the confirmation point. A design that confirms on the first miss, or on a step of exactly four lines, shows up as stray requests. A stream confirmed two lines before the page end must stop after one request: a design with no page clip emits the first line of the next page, and a design that lets the stream follow into the new page prefetches there without retraining. Restarting the lookahead on the following miss would reissue lines that were already sent, so the bench checks for exact request lists. It also holds pfReady low to catch a request that is overwritten or dropped, fills the table to make sure eviction picks the least recent stream and not a recently refreshed one, and checks a stream confirmed before a mid-run reset to make sure it is gone afterwards.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam int ADDR_W        = 32;
  localparam int LINE_SHIFT    = 6;
  localparam int PAGE_SHIFT    = 12;
  localparam int STREAMS       = 4;
  localparam int TRIGGER_BYTES = 256;
  localparam int LOOKAHEAD     = 2;

  localparam int LINE_W    = ADDR_W - LINE_SHIFT;
  localparam int OFS_W     = PAGE_SHIFT - LINE_SHIFT;
  localparam int IDX_W     = (STREAMS > 1) ? $clog2(STREAMS) : 1;
  localparam int THR_LINES = TRIGGER_BYTES >> LINE_SHIFT;

  typedef logic [LINE_W-1:0] lineT;

  typedef struct packed {
    logic valid;
    logic conf;
    logic desc;
    lineT lastLine;
    lineT nextLine;
  } streamT;

  typedef struct packed {
    logic             missTouch;
    logic             missAlloc;
    logic             missTrain;
    logic             trainDesc;
    logic [IDX_W-1:0] missIdx;
    logic             issueLoad;
    logic [IDX_W-1:0] issueIdx;
  } strobeT;

  function automatic logic samePage(lineT a, lineT b);
    return a[LINE_W-1:OFS_W] == b[LINE_W-1:OFS_W];
  endfunction
endpackage

// File: rtl/pfe_stream_ctrl.sv
module pfe_stream_ctrl
  import pfe_pkg::*;
(
  input  logic                          missValid,
  input  lineT                          missLine,
  input  streamT [STREAMS-1:0]          tbl,
  input  logic [STREAMS-1:0][IDX_W-1:0] age,
  input  logic                          pfValid,
  input  logic                          pfReady,
  output strobeT                        strb
);
  lineT diff [STREAMS];
  lineT magD [STREAMS];
  lineT lead [STREAMS];
  logic [STREAMS-1:0] near;
  logic [STREAMS-1:0] pend;

  for (genvar g = 0; g < STREAMS; g++) begin : g_entry
    // signed line distance of the miss from this stream's last miss
    assign diff[g] = missLine - tbl[g].lastLine;
    assign magD[g] = diff[g][LINE_W-1] ? lineT'(-diff[g]) : diff[g];
    assign near[g] = tbl[g].valid && samePage(missLine, tbl[g].lastLine) &&
                     (magD[g] < lineT'(THR_LINES));
    // how far the lookahead pointer stands past the last miss
    assign lead[g] = tbl[g].desc ? lineT'(tbl[g].lastLine - tbl[g].nextLine)
                                 : lineT'(tbl[g].nextLine - tbl[g].lastLine);
    assign pend[g] = tbl[g].valid && tbl[g].conf &&
                     samePage(tbl[g].nextLine, tbl[g].lastLine) &&
                     !lead[g][LINE_W-1] && (lead[g] != '0) &&
                     (lead[g] <= lineT'(LOOKAHEAD));
  end

  logic             hit, freeAny;
  logic [IDX_W-1:0] hitIdx, freeIdx, oldIdx, pendIdx;

  always_comb begin
    hit     = 1'b0;
    hitIdx  = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    oldIdx  = '0;
    pendIdx = '0;
    for (int i = STREAMS - 1; i >= 0; i--) begin
      if (near[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (!tbl[i].valid) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (age[i] == IDX_W'(STREAMS - 1)) oldIdx = IDX_W'(i);
      if (pend[i]) pendIdx = IDX_W'(i);
    end

    strb           = '0;
    strb.missTouch = missValid;
    strb.missAlloc = missValid && !hit;
    strb.missIdx   = hit ? hitIdx : (freeAny ? freeIdx : oldIdx);
    strb.missTrain = missValid && hit && (diff[hitIdx] != '0);
    strb.trainDesc = diff[hitIdx][LINE_W-1];
    // misses own the table in their cycle; issue waits one cycle
    strb.issueLoad = !missValid && (!pfValid || pfReady) && (|pend);
    strb.issueIdx  = pendIdx;
  end
endmodule

// File: rtl/pfe_stream_dp.sv
module pfe_stream_dp
  import pfe_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  lineT                          missLine,
  input  strobeT                        strb,
  input  logic                          pfReady,
  output streamT [STREAMS-1:0]          tbl,
  output logic [STREAMS-1:0][IDX_W-1:0] age,
  output logic                          pfValid,
  output logic [ADDR_W-1:0]             pfAddr
);
  streamT curE, trained;
  lineT   newLead, issueNext;
  logic   newDesc, keepNext;
  logic [STREAMS-1:0] validVec;

  for (genvar g = 0; g < STREAMS; g++) begin : g_valid
    assign validVec[g] = tbl[g].valid;
  end

  always_comb begin
    curE     = tbl[strb.missIdx];
    newDesc  = curE.conf ? curE.desc : strb.trainDesc;
    newLead  = newDesc ? lineT'(missLine - curE.nextLine)
                       : lineT'(curE.nextLine - missLine);
    keepNext = curE.conf && !newLead[LINE_W-1] && (newLead != '0);
    trained.valid    = 1'b1;
    trained.conf     = 1'b1;
    trained.desc     = newDesc;
    trained.lastLine = missLine;
    trained.nextLine = keepNext ? curE.nextLine
                     : (newDesc ? lineT'(missLine - lineT'(1)) : lineT'(missLine + lineT'(1)));
    issueNext = tbl[strb.issueIdx].desc ? lineT'(tbl[strb.issueIdx].nextLine - lineT'(1))
                                        : lineT'(tbl[strb.issueIdx].nextLine + lineT'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STREAMS; i++) tbl[i] <= '0;
    end else begin
      if (strb.missAlloc) begin
        tbl[strb.missIdx].valid    <= 1'b1;
        tbl[strb.missIdx].conf     <= 1'b0;
        tbl[strb.missIdx].desc     <= 1'b0;
        tbl[strb.missIdx].lastLine <= missLine;
        tbl[strb.missIdx].nextLine <= missLine;
      end else if (strb.missTrain) begin
        tbl[strb.missIdx] <= trained;
      end
      if (strb.issueLoad) tbl[strb.issueIdx].nextLine <= issueNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STREAMS; i++) age[i] <= IDX_W'(i);
    end else if (strb.missTouch) begin
      for (int i = 0; i < STREAMS; i++) begin
        if (IDX_W'(i) == strb.missIdx) age[i] <= '0;
        else if (age[i] < age[strb.missIdx]) age[i] <= age[i] + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfValid <= 1'b0;
      pfAddr  <= '0;
    end else if (strb.issueLoad) begin
      pfValid <= 1'b1;
      pfAddr  <= {tbl[strb.issueIdx].nextLine, {LINE_SHIFT{1'b0}}};
    end else if (pfReady) begin
      pfValid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    pfValid && !pfReady |=> pfValid && $stable(pfAddr)); // R9
  AST_ISSUE_CONFIRMED: assert property (@(posedge clk) disable iff (rst)
    strb.issueLoad |-> tbl[strb.issueIdx].conf); // R2
  AST_ISSUE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    strb.issueLoad |-> samePage(tbl[strb.issueIdx].nextLine, tbl[strb.issueIdx].lastLine)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pfValid && (validVec == '0)); // R1
endmodule

// File: rtl/pfe_stream_prefetch.sv
module pfe_stream_prefetch
  import pfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr,
  input  logic              pfReady
);
  lineT                          missLine;
  strobeT                        strb;
  streamT [STREAMS-1:0]          tbl;
  logic [STREAMS-1:0][IDX_W-1:0] age;

  assign missLine = missAddr[ADDR_W-1:LINE_SHIFT];

  pfe_stream_ctrl i_ctrl (
    .missValid (missValid),
    .missLine  (missLine),
    .tbl       (tbl),
    .age       (age),
    .pfValid   (pfValid),
    .pfReady   (pfReady),
    .strb      (strb)
  );

  pfe_stream_dp i_dp (
    .clk      (clk),
    .rst      (rst),
    .missLine (missLine),
    .strb     (strb),
    .pfReady  (pfReady),
    .tbl      (tbl),
    .age      (age),
    .pfValid  (pfValid),
    .pfAddr   (pfAddr)
  );
endmodule

// File: tb/test_pfe_stream_prefetch.sv
`timescale 1ns/1ps
module test_pfe_stream_prefetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        pfValid;
  logic [31:0] pfAddr;
  logic        pfReady = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [31:0] logAddr [64];
  int logCnt = 0;

  always #2 clk = ~clk;

  pfe_stream_prefetch i_pfe_stream_prefetch (
    .clk(clk), .rst(rst), .missValid(missValid), .missAddr(missAddr),
    .pfValid(pfValid), .pfAddr(pfAddr), .pfReady(pfReady)
  );

  // handshake seen at negedge completes at the following posedge
  always @(negedge clk) begin
    if (!rst && pfValid && pfReady) begin
      if (logCnt < 64) logAddr[logCnt] = pfAddr;
      logCnt = logCnt + 1;
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doMiss(input logic [31:0] a);
    @(posedge clk); #1;
    missValid = 1'b1;
    missAddr  = a;
    @(posedge clk); #1;
    missValid = 1'b0;
  endtask

  task automatic expectLog(input string req, input int n,
                           input logic [31:0] e0, input logic [31:0] e1);
    step(10);
    checkEq(req, "request count", logCnt, n);
    if (n > 0 && logCnt > 0) checkEq(req, "first request", logAddr[0], e0);
    if (n > 1 && logCnt > 1) checkEq(req, "second request", logAddr[1], e1);
    logCnt = 0;
  endtask

  task automatic tReset();
    step(3);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R1", "pfValid after reset", pfValid, 1'b0);
    logCnt = 0;
  endtask

  task automatic tAscend();
    doMiss(32'h0000_1000);
    expectLog("R2", 0, '0, '0);
    doMiss(32'h0000_1040);
    expectLog("R3", 2, 32'h0000_1080, 32'h0000_10C0);
    doMiss(32'h0000_10C0);   // +2 lines after +1: R7, no reissue: R5
    expectLog("R5", 2, 32'h0000_1100, 32'h0000_1140);
  endtask

  task automatic tWideStride();
    doMiss(32'h0000_5000);
    doMiss(32'h0000_5100);   // exactly 4 lines away
    expectLog("R6", 0, '0, '0);
    doMiss(32'h0000_5140);
    expectLog("R7", 2, 32'h0000_5180, 32'h0000_51C0);
  endtask

  task automatic tDescend();
    doMiss(32'h0000_8400);
    doMiss(32'h0000_83C0);
    expectLog("R4", 2, 32'h0000_8380, 32'h0000_8340);
    doMiss(32'h0000_8340);
    expectLog("R5", 2, 32'h0000_8300, 32'h0000_82C0);
  endtask

  task automatic tPage();
    doMiss(32'h0000_9F80);
    doMiss(32'h0000_9FC0);
    expectLog("R8", 0, '0, '0);
    doMiss(32'h0000_BF40);
    doMiss(32'h0000_BF80);
    expectLog("R8", 1, 32'h0000_BFC0, '0);
    doMiss(32'h0000_C000);
    expectLog("R8", 0, '0, '0);
    doMiss(32'h0000_C040);
    expectLog("R8", 2, 32'h0000_C080, 32'h0000_C0C0);
  endtask

  task automatic tRepeat();
    doMiss(32'h0000_D000);
    doMiss(32'h0000_D040);
    expectLog("R3", 2, 32'h0000_D080, 32'h0000_D0C0);
    doMiss(32'h0000_D040);
    expectLog("R10", 0, '0, '0);
  endtask

  task automatic tStall();
    pfReady = 1'b0;
    doMiss(32'h0000_E000);
    doMiss(32'h0000_E040);
    step(3);
    checkEq("R9", "pfValid under stall", pfValid, 1'b1);
    checkEq("R9", "pfAddr under stall", pfAddr, 32'h0000_E080);
    step(5);
    checkEq("R9", "pfAddr held", pfAddr, 32'h0000_E080);
    checkEq("R9", "nothing accepted", logCnt, 0);
    pfReady = 1'b1;
    expectLog("R9", 2, 32'h0000_E080, 32'h0000_E0C0);
  endtask

  task automatic tEvict();
    doMiss(32'h0002_0000);
    doMiss(32'h0002_1000);
    doMiss(32'h0002_2000);
    doMiss(32'h0002_3000);
    doMiss(32'h0002_0000);   // refresh recency only
    doMiss(32'h0002_4000);   // evicts the 0x21000 stream
    expectLog("R11", 0, '0, '0);
    doMiss(32'h0002_1040);
    expectLog("R11", 0, '0, '0);
    doMiss(32'h0002_0040);
    expectLog("R11", 2, 32'h0002_0080, 32'h0002_00C0);
  endtask

  task automatic tMidReset();
    pfReady = 1'b0;
    doMiss(32'h0003_0000);
    doMiss(32'h0003_0040);
    step(3);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R1", "pfValid after mid reset", pfValid, 1'b0);
    pfReady = 1'b1;
    logCnt = 0;
    doMiss(32'h0003_0080);
    expectLog("R1", 0, '0, '0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tAscend();
    tWideStride();
    tDescend();
    tPage();
    tRepeat();
    tStall();
    tEvict();
    tMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule